// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight separate interrupt request lines and presents them to a processor as a single request signal. Each request line is watched for a low-to-high transition; a transition marks that line as pending. The controller raises its request output whenever at least one pending line is not masked.

The processor answers with an acknowledge bus cycle. That cycle is timed like a read, but an active-low acknowledge strobe takes the place of the read strobe. On the first clock edge that sees the strobe low, the controller picks the pending, unmasked line with the highest priority. It clears that line's pending flag and latches an 8-bit answer byte. It drives the byte onto the data bus for as long as the strobe stays low.

A mode input, sampled at that same edge, selects the form of the answer byte:
- Restart mode returns a one-byte restart opcode. The opcode sends execution to a low-memory address that belongs to the winning line.
- Table mode returns a vector number. The processor uses this number to index a 256-entry jump table of 4-byte entries at the bottom of memory.

A small write port loads two registers: the table base and the mask.

Top module: `vic_core`

## Requirements
- R1: After reset, `irq_out` and `data_oe` are 0, the mask register is 0 (all lines enabled) and the table base is 8'h00.
- R2: A 0-to-1 change on `irq_in[i]` makes line i pending at the clock edge that samples it. From the following cycle, `irq_out` is 1 while any pending line is unmasked.
- R3: A write with `cfg_sel`=1 loads `cfg_wdata` into the mask. When mask bit i is 1, line i never raises `irq_out` and never wins an acknowledge, but its pending flag is kept. Clearing the mask bit later makes the line visible again.
- R4: Among the pending, unmasked lines, the lowest index wins. Line 0 has the highest priority.
- R5: The first clock edge that samples `inta_n` low after it was high chooses the winner and clears the winner's pending flag.
- R6: `data_oe` is 1 only while `inta_n` is low, from the cycle after the leading edge. `data_out` holds the same value for the whole time `inta_n` stays low.
- R7: When `restart_mode`=1 at the leading edge, the answer byte is {2'b11, N[2:0], 3'b111}, where N is the winning line index.
- R8: When `restart_mode`=0 at the leading edge, the answer byte is {base[7:3], N[2:0]}. The base is loaded by a write with `cfg_sel`=0.
- R9: If no pending, unmasked line exists at the leading edge, the answer uses N=7 and no pending flag changes.
- R10: If a new rising edge on line i is sampled at the same clock edge that delivers line i, line i stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| irq_in | input | 8 | Interrupt request lines, sensitive to rising edges |
| irq_out | output | 1 | Interrupt request to the processor |
| inta_n | input | 1 | Active-low interrupt acknowledge strobe |
| restart_mode | input | 1 | 1 selects the restart opcode answer, 0 selects the table vector answer |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 is the table base, 1 is the mask |
| cfg_wdata | input | 8 | Register write data |
| data_out | output | 8 | Answer byte for the data bus |
| data_oe | output | 1 | Data bus drive enable |

## Verification
Two functions can fall on the same clock edge: delivering a line, which clears its pending flag, and a fresh rising edge on that same line, which sets the flag. The bench provokes this by raising the line in the same cycle that it pulls `inta_n` low. It then checks at the ports that `irq_out` stays high and that the next acknowledge returns that line again. Random toggling of the request lines, mixed with random acknowledges, also produces this collision many times. A bench model resolves each collision in favour of the set, and the bench compares the design against that model.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_LINES  = 8;
  localparam int unsigned VIC_BYTE_W = 8;

  typedef logic [VIC_BYTE_W-1:0] vic_byte_t;

  typedef enum logic {
    VIC_SEL_BASE = 1'b0,
    VIC_SEL_MASK = 1'b1
  } vic_sel_e;
endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int unsigned LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         irq_in,
  input  logic                     clr_en,
  input  logic [$clog2(LINES)-1:0] clr_idx,
  output logic [LINES-1:0]         pend_o
);
  localparam int unsigned IDX_W = $clog2(LINES);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic smp_q;
    logic pend_q, pend_d;
    logic rise, hit;

    assign rise = irq_in[g] & ~smp_q;
    assign hit  = clr_en && (clr_idx == IDX_W'(g));

    // a new edge outranks delivery in the same cycle
    always_comb begin
      pend_d = pend_q;
      if (hit)  pend_d = 1'b0;
      if (rise) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        smp_q  <= irq_in[g];
        pend_q <= pend_d;
      end
    end

    assign pend_o[g] = pend_q;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in[g] && !smp_q) |=> pend_q);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !(irq_in[g] && !smp_q)) |=> !pend_q);
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned LINES = 8
) (
  input  logic [LINES-1:0]         req,
  output logic                     valid,
  output logic [$clog2(LINES)-1:0] idx
);
  localparam int unsigned IDX_W = $clog2(LINES);

  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_fmt.sv
module vic_fmt #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             restart_mode,
  input  logic [7:0]       base,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  logic [2:0] rst_field;
  logic [7:0] restart_byte, table_byte;

  assign rst_field    = 3'(idx);
  assign restart_byte = {2'b11, rst_field, 3'b111};
  assign table_byte   = {base[7:IDX_W], idx};
  assign byte_o       = restart_mode ? restart_byte : table_byte;
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int unsigned LINES = VIC_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  output logic             irq_out,
  input  logic             inta_n,
  input  logic             restart_mode,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       data_out,
  output logic             data_oe
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(LINES - 1);

  logic             srst_n;
  logic             inta_q;
  logic             lead;
  vic_byte_t        base_q, base_d;
  logic [LINES-1:0] mask_q, mask_d;
  logic             act_q, act_d;
  vic_byte_t        data_q, data_d;
  logic [LINES-1:0] pend;
  logic [LINES-1:0] req;
  logic             win_valid;
  logic [IDX_W-1:0] win_raw, win_idx;
  vic_byte_t        fmt_byte;
  logic             base_en, mask_en;

  vic_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign lead = inta_q & ~inta_n;

  vic_pending #(.LINES(LINES)) u_pend (
    .clk    (clk),
    .rst_n  (srst_n),
    .irq_in (irq_in),
    .clr_en (lead & win_valid),
    .clr_idx(win_idx),
    .pend_o (pend)
  );

  assign req = pend & ~mask_q;

  vic_prio #(.LINES(LINES)) u_prio (
    .req  (req),
    .valid(win_valid),
    .idx  (win_raw)
  );

  assign win_idx = win_valid ? win_raw : IDLE_IDX;

  vic_fmt #(.IDX_W(IDX_W)) u_fmt (
    .restart_mode(restart_mode),
    .base        (base_q),
    .idx         (win_idx),
    .byte_o      (fmt_byte)
  );

  // next state
  assign base_en = cfg_we && (vic_sel_e'(cfg_sel) == VIC_SEL_BASE);
  assign mask_en = cfg_we && (vic_sel_e'(cfg_sel) == VIC_SEL_MASK);

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    if (base_en) base_d = cfg_wdata;
    if (mask_en) mask_d = LINES'(cfg_wdata);
  end

  always_comb begin
    act_d  = act_q;
    data_d = data_q;
    if (lead) begin
      act_d  = 1'b1;
      data_d = fmt_byte;
    end else if (inta_n) begin
      act_d  = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      inta_q <= 1'b1;
      base_q <= '0;
      mask_q <= '0;
      act_q  <= 1'b0;
      data_q <= '0;
    end else begin
      inta_q <= inta_n;
      if (base_en) base_q <= base_d;
      if (mask_en) mask_q <= mask_d;
      act_q  <= act_d;
      if (lead) data_q <= data_d;
    end
  end

  assign irq_out  = |req;
  assign data_out = data_q;
  assign data_oe  = act_q & ~inta_n;

  // R4
  win_pending_chk: assert property (@(posedge clk) disable iff (!srst_n)
    win_valid |-> pend[win_idx]);

  // R4
  win_highest_chk: assert property (@(posedge clk) disable iff (!srst_n)
    win_valid |-> ((req & ((LINES'(1) << win_idx) - LINES'(1))) == '0));

  // R3
  win_unmasked_chk: assert property (@(posedge clk) disable iff (!srst_n)
    win_valid |-> !mask_q[win_idx]);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (act_q && !lead) |=> $stable(data_q));

  // R7
  restart_form_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (lead && restart_mode) |=> (data_q[7:6] == 2'b11 && data_q[2:0] == 3'b111));

  // R9
  idle_pick_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (lead && !win_valid && !restart_mode) |=> (data_q[IDX_W-1:0] == IDLE_IDX));
endmodule

// File: tb/vic_core_tb_top.sv
module vic_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_d = '0;
  logic       inta_n_d = 1'b1;
  logic       restart_d = 1'b0;
  logic       cfg_we_d = 1'b0;
  logic       cfg_sel_d = 1'b0;
  logic [7:0] cfg_wdata_d = '0;
  logic       irq_out;
  logic [7:0] data_out;
  logic       data_oe;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  // reference state
  logic [7:0] m_pend = '0, m_mask = '0, m_base = '0, m_irq_prev = '0;
  logic       m_inta_prev = 1'b1, m_act = 1'b0;
  logic [7:0] m_byte = '0;
  string      m_tag = "R8";

  always #2 clk = ~clk;

  vic_core dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_d), .irq_out(irq_out),
    .inta_n(inta_n_d), .restart_mode(restart_d), .cfg_we(cfg_we_d),
    .cfg_sel(cfg_sel_d), .cfg_wdata(cfg_wdata_d),
    .data_out(data_out), .data_oe(data_oe)
  );

  function automatic logic [2:0] pick(input logic [7:0] avail);
    for (int i = 0; i < 8; i++) if (avail[i]) return 3'(i);
    return 3'd7;
  endfunction

  function automatic logic [7:0] answer(input logic rm, input logic [7:0] base,
                                        input logic [2:0] n);
    return rm ? {2'b11, n, 3'b111} : {base[7:3], n};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: model update at the edge, port checks at the next falling edge
  task automatic cyc();
    logic [7:0] rise, avail;
    logic [2:0] n;
    @(posedge clk);
    rise = irq_d & ~m_irq_prev;
    if (m_inta_prev && !inta_n_d) begin
      avail  = m_pend & ~m_mask;
      n      = pick(avail);
      m_byte = answer(restart_d, m_base, n);
      m_tag  = (avail == 0) ? "R9" : (restart_d ? "R7" : "R8");
      if (avail != 0) m_pend[n] = 1'b0;
      m_act  = 1'b1;
    end else if (inta_n_d) begin
      m_act = 1'b0;
    end
    m_pend = m_pend | rise;
    if (cfg_we_d) begin
      if (cfg_sel_d) m_mask = cfg_wdata_d;
      else           m_base = cfg_wdata_d;
    end
    m_irq_prev  = irq_d;
    m_inta_prev = inta_n_d;
    @(negedge clk);
    check(irq_out == |(m_pend & ~m_mask), (m_mask != 0) ? "R3" : "R2",
          8'(irq_out), 8'(|(m_pend & ~m_mask)));
    check(data_oe == (m_act && !inta_n_d), "R6", 8'(data_oe),
          8'(m_act && !inta_n_d));
    if (m_act && !inta_n_d) check(data_out == m_byte, m_tag, data_out, m_byte);
  endtask

  task automatic ack(input logic rm, output logic [7:0] got);
    inta_n_d = 1'b0; restart_d = rm;
    cyc();
    got = data_out;
    cyc(); cyc();
    check(data_out == got, "R6", data_out, got);
    inta_n_d = 1'b1;
    cyc();
    check(data_oe == 1'b0, "R6", 8'(data_oe), 8'h00);
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    cfg_we_d = 1'b1; cfg_sel_d = sel; cfg_wdata_d = v;
    cyc();
    cfg_we_d = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int unsigned hold;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, and an idle acknowledge shows base 00 and line 7
    check(irq_out == 1'b0, "R1", 8'(irq_out), 8'h00);
    check(data_oe == 1'b0, "R1", 8'(data_oe), 8'h00);
    ack(1'b0, got);
    check(got == 8'h07, "R1", got, 8'h07);

    // R4, R5: lines 5 and 2 together, 2 first, then 5, then nothing
    irq_d = 8'h24; cyc();
    check(irq_out == 1'b1, "R2", 8'(irq_out), 8'h01);
    ack(1'b0, got);
    check(got == 8'h02, "R4", got, 8'h02);
    check(irq_out == 1'b1, "R5", 8'(irq_out), 8'h01);
    ack(1'b0, got);
    check(got == 8'h05, "R4", got, 8'h05);
    check(irq_out == 1'b0, "R5", 8'(irq_out), 8'h00);
    irq_d = 8'h00; cyc();

    // R3: a masked line is hidden but stays pending; R9 and R7 in restart mode
    wr(1'b1, 8'h02);
    irq_d = 8'h02; cyc();
    check(irq_out == 1'b0, "R3", 8'(irq_out), 8'h00);
    ack(1'b1, got);
    check(got == 8'hFF, "R9", got, 8'hFF);
    wr(1'b1, 8'h00);
    check(irq_out == 1'b1, "R3", 8'(irq_out), 8'h01);
    ack(1'b1, got);
    check(got == 8'hCF, "R7", got, 8'hCF);
    irq_d = 8'h00; cyc();

    // R8: table mode with a loaded base
    wr(1'b0, 8'hA5);
    irq_d = 8'h08; cyc();
    ack(1'b0, got);
    check(got == 8'hA3, "R8", got, 8'hA3);

    // R10: line 4 pending, then re-raised on the very edge that delivers it
    irq_d = 8'h10; cyc();
    irq_d = 8'h00; cyc();
    irq_d = 8'h10; inta_n_d = 1'b0; restart_d = 1'b0;
    cyc();
    check(data_out == 8'hA4, "R10", data_out, 8'hA4);
    check(irq_out == 1'b1, "R10", 8'(irq_out), 8'h01);
    inta_n_d = 1'b1; cyc();
    ack(1'b0, got);
    check(got == 8'hA4, "R10", got, 8'hA4);
    irq_d = 8'h00; cyc();

    // random mix, checked every cycle against the model
    hold = 0;
    for (int k = 0; k < 4000; k++) begin
      for (int b = 0; b < 8; b++) if ($urandom % 6 == 0) irq_d[b] = ~irq_d[b];
      if (hold > 0) begin
        hold--;
        if (hold == 0) inta_n_d = 1'b1;
      end else if (inta_n_d && $urandom % 5 == 0) begin
        inta_n_d = 1'b0; restart_d = 1'($urandom); hold = 1 + $urandom % 4;
      end
      cfg_we_d = 1'b0;
      if (inta_n_d && m_inta_prev && $urandom % 25 == 0) begin
        cfg_we_d = 1'b1; cfg_sel_d = 1'($urandom); cfg_wdata_d = 8'($urandom);
        if (cfg_sel_d) cfg_wdata_d = cfg_wdata_d & 8'($urandom);
      end
      cyc();
    end
    cfg_we_d = 1'b0; inta_n_d = 1'b1; cyc();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule